// File: doc/BRIEF.md
# Compare Timebase with Wake-Event Stream

This block is a 64-bit system timebase. A physical count starts from zero at hardware reset and then rises by one on every clock. Software cannot write it. Software sets a 64-bit offset, and the block subtracts it from the physical count to form a virtual count. Rewriting the offset is therefore the only way to restart a timebase. A single compare channel watches the virtual count and raises a level interrupt. Periodic operation works this way: after each expiry, software adds a fixed step to the old compare value.

The block has two compare modes. In the default mode, the channel fires whenever the virtual count is at or past the compare value. A deadline that has already passed therefore fires at once. In the alternative mode, only the low 32 bits are compared, and the channel fires only on an exact match. A separate event output pulses at a fixed rate taken from a selected bit of the physical count. A sleeping core can use it as a periodic wake source, independent of the compare channel.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Read data is combinational from the address while `rdEn` is high.

Top module: `cmp_timebase`

## Requirements
- R1: The physical count is 64 bits. It is 0 after reset and rises by exactly 1 each clock. Writes to its addresses (2 and 3) have no effect on it.
- R2: Register addresses: 0 control, 1 status, 2/3 physical low/high, 4/5 virtual low/high, 6/7 offset low/high, 8/9 compare low/high. Control fields are as follows. Bit 0 enables the channel. Bit 1 masks the interrupt. Bit 2 enables the event stream. Bit 3 selects exact low-half compare. Bit 4 selects a 1→0 event edge (0 selects 0→1). Bits 8:5 give the event bit index.
- R3: The virtual count equals the physical count minus the offset, modulo 2^64.
- R4: In default mode, status bit 0 is the level of (virtual ≥ compare), unsigned over 64 bits. A compare value written in the past takes effect in the first cycle after the write edge.
- R5: `irqOut` is high exactly when the channel is enabled, the compare condition holds, and the mask is clear. It drops in the first cycle after the compare is moved into the future. The mask hides only the interrupt, not status.
- R6: In exact mode, the condition holds only while the virtual low 32 bits equal the compare low 32 bits. The compare high half has no effect. A value that has been passed does not fire again.
- R7: A read of a low half (address 2 or 4) captures the matching high half at that edge. A later read of the high half (3 or 5) returns the captured value, so a pair of reads stays coherent across a carry.
- R8: With the event stream enabled and index k, `evtOut` pulses for one cycle when count bit k rises (physical count low k+1 bits equal 2^k). In falling mode, it pulses when bit k falls (low k+1 bits equal 0).
- R9: With the event stream disabled, `evtOut` stays low.
- R10: After reset, control, status and offset read 0, both compare halves read all ones, and `irqOut` and `evtOut` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; count advances on each rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (captures high halves) |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irqOut | output | 1 | Level compare interrupt |
| evtOut | output | 1 | Single-cycle wake-event pulse |

## Verification
A wrong offset or compare register shows up as an `irqOut` edge that comes one or more cycles early or late against a deadline the bench places 30 to 40 cycles ahead. A stuck condition shows up instead as an interrupt that fails to drop in the cycle after the compare moves forward. A broken high-half capture only shows when a low/high read pair straddles a carry. The bench places the virtual count so that the low read lands on 0xFFFFFFFF. A wrong event-bit select or edge polarity moves every `evtOut` pulse away from the residue of the cycle count, so it shows within one event period.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int ADDR_W    = 4;
  localparam int EVT_SEL_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_STAT    = 4'd1,
    A_PHYS_LO = 4'd2,
    A_PHYS_HI = 4'd3,
    A_VIRT_LO = 4'd4,
    A_VIRT_HI = 4'd5,
    A_OFF_LO  = 4'd6,
    A_OFF_HI  = 4'd7,
    A_CMP_LO  = 4'd8,
    A_CMP_HI  = 4'd9
  } regAddr_e;

  // en is bit 0, evtSel occupies the top bits
  typedef struct packed {
    logic [EVT_SEL_W-1:0] evtSel;
    logic                 evtFall;
    logic                 cmpExact;
    logic                 evtEn;
    logic                 irqMask;
    logic                 en;
  } ctrlReg_t;

  localparam int CTRL_W = $bits(ctrlReg_t);

  typedef struct packed {
    logic wrOffLo;
    logic wrOffHi;
    logic wrCmpLo;
    logic wrCmpHi;
    logic capPhys;
    logic capVirt;
  } dpStrobe_t;
endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wrCtrl,
  output ctrlReg_t          ctrlQ,
  output dpStrobe_t         stb
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlQ <= '0;
    end else if (wrEn && (addr == A_CTRL)) begin
      ctrlQ <= ctrlReg_t'(wrCtrl);
    end
  end

  always_comb begin
    stb.wrOffLo = wrEn && (addr == A_OFF_LO);
    stb.wrOffHi = wrEn && (addr == A_OFF_HI);
    stb.wrCmpLo = wrEn && (addr == A_CMP_LO);
    stb.wrCmpHi = wrEn && (addr == A_CMP_HI);
    stb.capPhys = rdEn && (addr == A_PHYS_LO);
    stb.capVirt = rdEn && (addr == A_VIRT_LO);
  end
endmodule

// File: rtl/timebase_dp.sv
module timebase_dp
  import timebase_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpStrobe_t            stb,
  input  logic                 exactMode,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [CTRL_W-1:0]    ctrlWord,
  input  logic [REG_W-1:0]     wrData,
  output logic [2*REG_W-1:0]   physCnt,
  output logic                 condRaw,
  output logic [REG_W-1:0]     rdData
);
  localparam int CNT_W = 2 * REG_W;

  logic [CNT_W-1:0] offQ;
  logic [CNT_W-1:0] cmpQ;
  logic [CNT_W-1:0] virtCnt;
  logic [REG_W-1:0] physHiHold;
  logic [REG_W-1:0] virtHiHold;
  logic             geHit;
  logic             eqHit;

  // free-running count; only hardware reset clears it
  always_ff @(posedge clk) begin
    if (rst) physCnt <= '0;
    else     physCnt <= physCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offQ <= '0;
      cmpQ <= '1;
    end else begin
      if (stb.wrOffLo) offQ[REG_W-1:0]     <= wrData;
      if (stb.wrOffHi) offQ[CNT_W-1:REG_W] <= wrData;
      if (stb.wrCmpLo) cmpQ[REG_W-1:0]     <= wrData;
      if (stb.wrCmpHi) cmpQ[CNT_W-1:REG_W] <= wrData;
    end
  end

  assign virtCnt = physCnt - offQ;

  // high halves frozen by a low-half read
  always_ff @(posedge clk) begin
    if (rst) begin
      physHiHold <= '0;
      virtHiHold <= '0;
    end else begin
      if (stb.capPhys) physHiHold <= physCnt[CNT_W-1:REG_W];
      if (stb.capVirt) virtHiHold <= virtCnt[CNT_W-1:REG_W];
    end
  end

  assign geHit   = (virtCnt >= cmpQ);
  assign eqHit   = (virtCnt[REG_W-1:0] == cmpQ[REG_W-1:0]);
  assign condRaw = exactMode ? eqHit : geHit;

  always_comb begin
    case (rdAddr)
      A_CTRL:    rdData = REG_W'(ctrlWord);
      A_STAT:    rdData = REG_W'(condRaw);
      A_PHYS_LO: rdData = physCnt[REG_W-1:0];
      A_PHYS_HI: rdData = physHiHold;
      A_VIRT_LO: rdData = virtCnt[REG_W-1:0];
      A_VIRT_HI: rdData = virtHiHold;
      A_OFF_LO:  rdData = offQ[REG_W-1:0];
      A_OFF_HI:  rdData = offQ[CNT_W-1:REG_W];
      A_CMP_LO:  rdData = cmpQ[REG_W-1:0];
      A_CMP_HI:  rdData = cmpQ[CNT_W-1:REG_W];
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/timebase_evt.sv
module timebase_evt #(
  parameter int CNT_W = 64,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] physCnt,
  input  logic [SEL_W-1:0] bitSel,
  input  logic             fallEdge,
  input  logic             streamEn,
  output logic             evtPulse
);
  localparam int IDX_W = $clog2(CNT_W);

  logic curBit;
  logic prevBit;

  assign curBit = physCnt[IDX_W'(bitSel)];

  always_ff @(posedge clk) begin
    if (rst) prevBit <= 1'b0;
    else     prevBit <= curBit;
  end

  assign evtPulse = streamEn &&
                    (fallEdge ? (prevBit && !curBit) : (curBit && !prevBit));
endmodule

// File: rtl/cmp_timebase.sv
module cmp_timebase
  import timebase_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              irqOut,
  output logic              evtOut
);
  localparam int CNT_W = 2 * REG_W;

  ctrlReg_t         ctrlQ;
  dpStrobe_t        stb;
  logic [CNT_W-1:0] physCnt;
  logic             condRaw;

  timebase_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .addr   (addr),
    .wrCtrl (wrData[CTRL_W-1:0]),
    .ctrlQ  (ctrlQ),
    .stb    (stb)
  );

  timebase_dp #(.REG_W(REG_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .exactMode (ctrlQ.cmpExact),
    .rdAddr    (addr),
    .ctrlWord  (ctrlQ),
    .wrData    (wrData),
    .physCnt   (physCnt),
    .condRaw   (condRaw),
    .rdData    (rdData)
  );

  timebase_evt #(.CNT_W(CNT_W), .SEL_W(EVT_SEL_W)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .physCnt  (physCnt),
    .bitSel   (ctrlQ.evtSel),
    .fallEdge (ctrlQ.evtFall),
    .streamEn (ctrlQ.evtEn),
    .evtPulse (evtOut)
  );

  assign irqOut = ctrlQ.en && condRaw && !ctrlQ.irqMask;
endmodule

// File: rtl/timebase_chk.sv
module timebase_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic             irqOut,
  input logic             evtOut,
  input logic             condRaw,
  input logic             chEn,
  input logic             chMask,
  input logic             chExact,
  input logic [CNT_W-1:0] physCnt
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> physCnt == $past(physCnt) + CNT_W'(1));

  // R4
  ge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (condRaw && !chExact && !wrEn) |=> condRaw);

  // R5
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (condRaw && chEn && !chMask && !chExact && !wrEn) |=> irqOut);

  // R6
  exact_once_chk: assert property (@(posedge clk) disable iff (rst)
    (condRaw && chExact && !wrEn) |=> !condRaw);

  // R8
  evt_single_chk: assert property (@(posedge clk) disable iff (rst)
    (evtOut && !wrEn) |=> !evtOut);
endmodule

bind cmp_timebase timebase_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wrEn    (wrEn),
  .irqOut  (irqOut),
  .evtOut  (evtOut),
  .condRaw (condRaw),
  .chEn    (ctrlQ.en),
  .chMask  (ctrlQ.irqMask),
  .chExact (ctrlQ.cmpExact),
  .physCnt (physCnt)
);

// File: tb/sim_cmp_timebase.sv
module sim_cmp_timebase;
  import timebase_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;
  logic        evtOut;

  logic [63:0] cyc = '0;
  logic [63:0] offM = '0;
  logic [31:0] pHiM = '0;
  logic [31:0] vHiM = '0;
  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  logic [31:0] expQ[$];
  string       reqQ[$];

  always #2 clk = ~clk;

  cmp_timebase u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .evtOut(evtOut)
  );

  // R1 model: zero in reset, +1 per clock afterwards
  always @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 64'd1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  // scoreboard monitor: pops expected read data mid-cycle
  always @(negedge clk) begin
    if (!rst && rdEn) begin
      if (expQ.size() == 0) check("SB empty queue", 64'd1, 64'd0);
      else check(reqQ.pop_front(), {32'h0, rdData}, {32'h0, expQ.pop_front()});
    end
  end

  task automatic op(input bit w, input bit r, input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wrEn = w; rdEn = r; addr = a; wrData = d;
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 4'd0, 32'd0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    op(1'b1, 1'b0, a, d);
    if (a == A_OFF_LO) offM[31:0]  = d;
    if (a == A_OFF_HI) offM[63:32] = d;
  endtask

  // kind: 0 fixed value, 1 phys lo, 2 phys hi, 3 virt lo, 4 virt hi
  task automatic rd(input int kind, input logic [3:0] a, input string req,
                    input logic [31:0] fixedE = 32'd0);
    logic [31:0] e;
    logic [63:0] v;
    op(1'b0, 1'b1, a, 32'd0);
    v = cyc - offM;
    case (kind)
      1: begin e = cyc[31:0]; pHiM = cyc[63:32]; end
      2: e = pHiM;
      3: begin e = v[31:0]; vHiM = v[63:32]; end
      4: e = vHiM;
      default: e = fixedE;
    endcase
    expQ.push_back(e);
    reqQ.push_back(req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [63:0] offNew;
    logic [63:0] tgt;
    int hits;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R10 reset values
    rd(0, A_CTRL,   "R10 ctrl",    32'h0);
    rd(0, A_STAT,   "R10 status",  32'h0);
    rd(0, A_CMP_LO, "R10 cmp lo",  32'hFFFF_FFFF);
    rd(0, A_CMP_HI, "R10 cmp hi",  32'hFFFF_FFFF);
    rd(0, A_OFF_LO, "R10 off lo",  32'h0);
    idle();
    @(negedge clk);
    check("R10 irq", irqOut, 0);
    check("R10 evt", evtOut, 0);

    // R1 counting and write protection
    rd(1, A_PHYS_LO, "R1 phys lo");
    rd(2, A_PHYS_HI, "R7 phys hi");
    repeat (5) idle();
    rd(1, A_PHYS_LO, "R1 phys lo later");
    wr(A_PHYS_LO, 32'h0);
    wr(A_PHYS_HI, 32'hFFFF);
    idle();
    rd(1, A_PHYS_LO, "R1 write ignored lo");
    rd(2, A_PHYS_HI, "R1 write ignored hi");

    // R3 virtual count, including wrap below zero
    wr(A_OFF_LO, 32'd1000);
    wr(A_OFF_HI, 32'd0);
    idle();
    rd(3, A_VIRT_LO, "R3 virt lo");
    rd(4, A_VIRT_HI, "R3 virt hi");
    wr(A_OFF_LO, 32'd10);
    idle();
    rd(3, A_VIRT_LO, "R3 virt lo small offset");
    rd(0, A_OFF_LO,  "R2 off readback", 32'd10);

    // R7 coherent pair across a low-half carry
    @(posedge clk); #1;
    offNew = cyc + 64'd3 - 64'h0000_0000_FFFF_FFFF;
    offM = offNew;
    wrEn = 1'b1; rdEn = 1'b0; addr = A_OFF_LO; wrData = offNew[31:0];
    wr(A_OFF_HI, offNew[63:32]);
    idle();
    rd(3, A_VIRT_LO, "R7 virt lo at carry");
    rd(4, A_VIRT_HI, "R7 virt hi coherent");
    idle();
    check("R7 placement", vHiM, 0);

    // R4 / R5 greater-or-equal channel
    wr(A_OFF_LO, 32'd0);
    wr(A_OFF_HI, 32'd0);
    wr(A_CTRL, 32'h1);
    tgt = cyc + 64'd40;
    wr(A_CMP_LO, tgt[31:0]);
    wr(A_CMP_HI, tgt[63:32]);
    idle();
    @(negedge clk);
    check("R4 future compare", irqOut, 0);
    while (cyc != tgt - 64'd1) @(negedge clk);
    check("R4 one before deadline", irqOut, 0);
    @(negedge clk);
    check("R4 at deadline", irqOut, 1);
    rd(0, A_STAT, "R4 status", 32'h1);
    wr(A_CMP_HI, 32'hFFFF_FFFF);
    idle();
    @(negedge clk);
    check("R5 moved to future", irqOut, 0);
    wr(A_CMP_LO, 32'h0);
    wr(A_CMP_HI, 32'h0);
    idle();
    @(negedge clk);
    check("R4 past compare fires", irqOut, 1);

    // R5 mask and enable
    wr(A_CTRL, 32'h3);
    idle();
    @(negedge clk);
    check("R5 masked", irqOut, 0);
    rd(0, A_STAT, "R5 status under mask", 32'h1);
    wr(A_CTRL, 32'h0);
    idle();
    @(negedge clk);
    check("R5 disabled", irqOut, 0);
    wr(A_CTRL, 32'h1);
    idle();
    @(negedge clk);
    check("R5 re-enabled", irqOut, 1);

    // R6 exact low-half match
    wr(A_CTRL, 32'h9);
    wr(A_CMP_HI, 32'h1234_5678);
    tgt = cyc + 64'd30;
    wr(A_CMP_LO, tgt[31:0]);
    idle();
    hits = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (irqOut) hits++;
      if (cyc[31:0] == tgt[31:0]) check("R6 match cycle", irqOut, 1);
    end
    check("R6 single hit", hits, 1);

    // R8 event stream, bit 2 rising (0x44), falling (0x54), bit 0 rising (0x04)
    wr(A_CTRL, 32'h44);
    idle(); idle();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check("R8 rise k2", evtOut, cyc[2:0] == 3'd4);
    end
    wr(A_CTRL, 32'h54);
    idle(); idle();
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      check("R8 fall k2", evtOut, cyc[2:0] == 3'd0);
    end
    wr(A_CTRL, 32'h04);
    idle(); idle();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R8 rise k0", evtOut, cyc[0] == 1'b1);
    end

    // R9 stream disabled
    wr(A_CTRL, 32'h40);
    idle(); idle();
    hits = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (evtOut) hits++;
    end
    check("R9 no events", hits, 0);

    idle();
    @(negedge clk);
    check("SB drained", expQ.size(), 0);
    finishRun();
  end
endmodule